// File: doc/BRIEF.md
# Multi-Stream Timestamped Measurement Packetizer

This block gathers samples from several independent probe streams. Each stream arrives through its own valid/ready sample port, such as the read side of a small FIFO. Every stream has three settings of its own: an on/off switch, a keep-one-in-N thinning factor and an output word format. Kept samples are widened into a common output word and stored in a per-stream packet buffer. When a buffer holds the configured number of words, the stream raises a packet-ready flag.

An output engine chooses one ready stream in round-robin order and sends a whole packet on an AXI4-Stream-style master port. The packet is one header word followed by the payload words. The header carries the fixed stream number and a timestamp. The timestamp is taken from a free-running cycle counter that all streams share, so the host can line up separate streams on one time axis after it splits them apart. A small command port writes the per-stream settings and the global packet length, and acknowledges each command.

Each lane runs a state machine with the states LN_EMPTY, LN_FILL and LN_HELD:
- LN_EMPTY to LN_FILL: the first sample is kept and the packet length is above one.
- LN_EMPTY to LN_HELD: the first sample is kept and the length is one.
- LN_FILL to LN_HELD: the last payload word is kept.
- LN_HELD to LN_EMPTY: the output engine drains the packet.

The output engine runs TX_PICK, TX_HEAD and TX_BODY:
- TX_PICK to TX_HEAD: at least one lane is held.
- TX_HEAD to TX_BODY: the header is accepted.
- TX_BODY to TX_PICK: the last payload word is accepted.

Top module: `meas_packer`

## Requirements
- R1: Each packet is one header word followed by its payload words. The header holds the stream index in bits [31:28] and the timestamp in bits [27:0].
- R2: The timestamp is a free-running count of clock cycles since reset was released. It is captured at the clock edge that accepts the first kept sample of the packet.
- R3: Format codes (command op 2, arg[1:0]) are:
  - 0: the sample zero-extended to 32 bits.
  - 1: the sample sign-extended from bit 15.
  - 2: sample bits [15:8] zero-extended.
  - 3: the same as 0.
  A packet uses the format in force when its first sample was kept.
- R4: Thinning value D (command op 1, arg[3:0]) keeps one accepted sample and then discards the next D. Discarded samples are still consumed, with s_ready high. Disabling a stream restarts its thinning count, so the next accepted sample is kept.
- R5: A disabled stream (command op 0, arg[0]=0) holds s_ready low and takes no samples. All streams are disabled after reset.
- R6: The packet length (command op 3, arg[7:0], stream field ignored) is clamped: 0 becomes 1, and any value above 8 becomes 8. A packet uses the length in force when its first sample was kept, and nothing of it is sent before it is complete.
- R7: m_tlast is high only on the final payload word of a packet, never on the header.
- R8: Packets leave whole and never interleave. Among streams that are ready together, service starts at the stream after the one served last; after reset, that is stream 0.
- R9: cmd_ack pulses high for exactly the cycle after each cycle with cmd_valid high, by which time the setting has been applied.
- R10: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values.
- R11: After reset, m_tvalid, m_tlast, cmd_ack and every s_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 3 | Per-stream sample valid |
| s_data | input | 48 | Per-stream samples, stream i in bits [16i+15:16i] |
| s_ready | output | 3 | Per-stream sample accept |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 enable, 1 thinning, 2 format, 3 length |
| cmd_stream | input | 4 | Target stream index |
| cmd_arg | input | 8 | Command argument |
| cmd_ack | output | 1 | Command applied |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Output word accept |
| m_tdata | output | 32 | Header or payload word |
| m_tlast | output | 1 | Final payload word |

## Verification
The cycle-by-cycle properties are checked on every clock:
- the acknowledge timing;
- the output holding still under back-pressure;
- m_tlast never appearing without m_tvalid;
- a disabled stream never offering s_ready.

Some behaviours can only be shown by the bench's scenarios, because they depend on packet contents and ordering: the format conversions, the thinning pattern, the captured timestamps, length clamping, settings taking effect only at packet boundaries, and the round-robin order when three packets become ready in the same cycle.

// File: rtl/meas_pkg.sv
`timescale 1ns/1ps
package meas_pkg;
    typedef enum logic [1:0] {FMT_RAW = 2'd0, FMT_SEXT = 2'd1, FMT_TOP = 2'd2, FMT_ALT = 2'd3} fmt_e;
    typedef enum logic [1:0] {OP_ENABLE = 2'd0, OP_DECIM = 2'd1, OP_FORMAT = 2'd2, OP_LENGTH = 2'd3} op_e;
    typedef enum logic [1:0] {LN_EMPTY, LN_FILL, LN_HELD} lane_st_e;
    typedef enum logic [1:0] {TX_PICK, TX_HEAD, TX_BODY} tx_st_e;
endpackage

// File: rtl/cfg_ctrl.sv
`timescale 1ns/1ps
module cfg_ctrl
    import meas_pkg::*;
#(
    parameter int NUM_STREAMS = 3,
    parameter int ID_W        = 4,
    parameter int DEC_W       = 4,
    parameter int MAX_LEN     = 8,
    parameter int DEF_LEN     = 4,
    localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cmd_valid,
    input  logic [1:0]                          cmd_op,
    input  logic [ID_W-1:0]                     cmd_stream,
    input  logic [7:0]                          cmd_arg,
    output logic                                cmd_ack,
    output logic [NUM_STREAMS-1:0]              en_o,
    output logic [NUM_STREAMS-1:0][DEC_W-1:0]   dec_o,
    output logic [NUM_STREAMS-1:0][1:0]         fmt_o,
    output logic [LEN_W-1:0]                    len_o
);
    localparam logic [7:0] MAX_ARG = 8'(MAX_LEN);

    op_e              op;
    logic [LEN_W-1:0] len_clamped;

    assign op = op_e'(cmd_op);

    // Length arguments outside 1..MAX_LEN are pulled to the nearest limit.
    always_comb begin
        if (cmd_arg == 8'd0)
            len_clamped = LEN_W'(1);
        else if (cmd_arg > MAX_ARG)
            len_clamped = LEN_W'(MAX_LEN);
        else
            len_clamped = cmd_arg[LEN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_ack <= 1'b0;
            len_o   <= LEN_W'(DEF_LEN);
        end else begin
            cmd_ack <= cmd_valid;
            if (cmd_valid && op == OP_LENGTH)
                len_o <= len_clamped;
        end
    end

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_stream
        logic hit;
        assign hit = cmd_valid && (cmd_stream == ID_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_o[i]  <= 1'b0;
                dec_o[i] <= '0;
                fmt_o[i] <= FMT_RAW;
            end else if (hit) begin
                unique case (op)
                    OP_ENABLE: en_o[i]  <= cmd_arg[0];
                    OP_DECIM:  dec_o[i] <= cmd_arg[DEC_W-1:0];
                    OP_FORMAT: fmt_o[i] <= cmd_arg[1:0];
                    OP_LENGTH: ;
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/stream_lane.sv
`timescale 1ns/1ps
module stream_lane
    import meas_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int WORD_W   = 32,
    parameter int DEC_W    = 4,
    parameter int TS_W     = 28,
    parameter int MAX_LEN  = 8,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int IDX_W   = $clog2(MAX_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [DEC_W-1:0]    dec,
    input  logic [1:0]          fmt,
    input  logic [LEN_W-1:0]    len,
    input  logic [TS_W-1:0]     ts_now,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_data,
    output logic                s_ready,
    input  logic                drain,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic                held,
    output logic [TS_W-1:0]     ts_o,
    output logic [LEN_W-1:0]    len_o,
    output logic [WORD_W-1:0]   rd_word
);
    localparam int HALF_W = SAMPLE_W / 2;

    lane_st_e          state, state_nx;
    logic [DEC_W-1:0]  dcnt;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  len_q;
    fmt_e              fmt_q, fmt_use;
    logic [TS_W-1:0]   ts_q;
    logic [WORD_W-1:0] pkt_mem [MAX_LEN];
    logic [IDX_W-1:0]  wr_idx;
    logic              take, keep;

    function automatic logic [WORD_W-1:0] widen(fmt_e f, logic [SAMPLE_W-1:0] d);
        case (f)
            FMT_SEXT: return {{(WORD_W-SAMPLE_W){d[SAMPLE_W-1]}}, d};
            FMT_TOP:  return WORD_W'(d[SAMPLE_W-1 -: HALF_W]);
            default:  return WORD_W'(d);
        endcase
    endfunction

    assign s_ready = en && (state != LN_HELD);
    assign take    = s_valid && s_ready;
    assign keep    = take && (dcnt == '0);
    assign fmt_use = (state == LN_EMPTY) ? fmt_e'(fmt) : fmt_q;
    assign wr_idx  = (state == LN_EMPTY) ? '0 : cnt[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LN_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LN_EMPTY: if (keep) state_nx = (len == LEN_W'(1)) ? LN_HELD : LN_FILL;
            LN_FILL:  if (keep && (cnt + LEN_W'(1) == len_q)) state_nx = LN_HELD;
            LN_HELD:  if (drain) state_nx = LN_EMPTY;
            default:  state_nx = LN_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt  <= '0;
            cnt   <= '0;
            len_q <= '0;
            fmt_q <= FMT_RAW;
            ts_q  <= '0;
        end else begin
            if (!en)
                dcnt <= '0;
            else if (take)
                dcnt <= (dcnt >= dec) ? '0 : dcnt + DEC_W'(1);
            if (keep) begin
                if (state == LN_EMPTY) begin
                    ts_q  <= ts_now;
                    len_q <= len;
                    fmt_q <= fmt_e'(fmt);
                    cnt   <= LEN_W'(1);
                end else begin
                    cnt <= cnt + LEN_W'(1);
                end
            end
            if (state == LN_HELD && drain)
                cnt <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (keep)
            pkt_mem[wr_idx] <= widen(fmt_use, s_data);
    end

    assign held    = (state == LN_HELD);
    assign ts_o    = ts_q;
    assign len_o   = len_q;
    assign rd_word = pkt_mem[rd_idx];
endmodule

// File: rtl/pkt_tx.sv
`timescale 1ns/1ps
module pkt_tx
    import meas_pkg::*;
#(
    parameter int NUM_STREAMS = 3,
    parameter int ID_W        = 4,
    parameter int WORD_W      = 32,
    parameter int TS_W        = 28,
    parameter int MAX_LEN     = 8,
    localparam int LEN_W      = $clog2(MAX_LEN + 1),
    localparam int IDX_W      = $clog2(MAX_LEN),
    localparam int SEL_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_STREAMS-1:0]              held,
    input  logic [NUM_STREAMS-1:0][TS_W-1:0]    ts_in,
    input  logic [NUM_STREAMS-1:0][LEN_W-1:0]   len_in,
    input  logic [NUM_STREAMS-1:0][WORD_W-1:0]  word_in,
    output logic [NUM_STREAMS-1:0]              drain,
    output logic [IDX_W-1:0]                    rd_idx,
    output logic                                m_tvalid,
    input  logic                                m_tready,
    output logic [WORD_W-1:0]                   m_tdata,
    output logic                                m_tlast
);
    tx_st_e           state, state_nx;
    logic [SEL_W-1:0] grant, last_g, pick;
    logic [LEN_W-1:0] idx;
    logic             found, final_word;

    // Round-robin search beginning just after the last stream served.
    always_comb begin
        logic [SEL_W-1:0] c;
        found = 1'b0;
        pick  = last_g;
        for (int k = 1; k <= NUM_STREAMS; k++) begin
            c = SEL_W'((int'(last_g) + k) % NUM_STREAMS);
            if (!found && held[c]) begin
                found = 1'b1;
                pick  = c;
            end
        end
    end

    assign final_word = (idx + LEN_W'(1)) == len_in[grant];
    assign rd_idx     = idx[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_PICK;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_PICK: if (found) state_nx = TX_HEAD;
            TX_HEAD: if (m_tready) state_nx = TX_BODY;
            TX_BODY: if (m_tready && final_word) state_nx = TX_PICK;
            default: state_nx = TX_PICK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant  <= '0;
            last_g <= SEL_W'(NUM_STREAMS - 1);
            idx    <= '0;
        end else begin
            unique case (state)
                TX_PICK: if (found) grant <= pick;
                TX_HEAD: if (m_tready) idx <= '0;
                TX_BODY: if (m_tready) begin
                    if (final_word) last_g <= grant;
                    else            idx <= idx + LEN_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        m_tvalid = 1'b0;
        m_tdata  = '0;
        m_tlast  = 1'b0;
        drain    = '0;
        unique case (state)
            TX_PICK: ;
            TX_HEAD: begin
                m_tvalid = 1'b1;
                m_tdata  = {ID_W'(grant), ts_in[grant]};
            end
            TX_BODY: begin
                m_tvalid = 1'b1;
                m_tdata  = word_in[grant];
                m_tlast  = final_word;
                if (m_tready && final_word) drain[grant] = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/meas_packer.sv
`timescale 1ns/1ps
module meas_packer #(
    parameter int NUM_STREAMS = 3,
    parameter int SAMPLE_W    = 16,
    parameter int WORD_W      = 32,
    parameter int ID_W        = 4,
    parameter int DEC_W       = 4,
    parameter int MAX_LEN     = 8,
    parameter int DEF_LEN     = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_STREAMS-1:0]          s_valid,
    input  logic [NUM_STREAMS*SAMPLE_W-1:0] s_data,
    output logic [NUM_STREAMS-1:0]          s_ready,
    input  logic                            cmd_valid,
    input  logic [1:0]                      cmd_op,
    input  logic [ID_W-1:0]                 cmd_stream,
    input  logic [7:0]                      cmd_arg,
    output logic                            cmd_ack,
    output logic                            m_tvalid,
    input  logic                            m_tready,
    output logic [WORD_W-1:0]               m_tdata,
    output logic                            m_tlast
);
    localparam int TS_W  = WORD_W - ID_W;
    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam int IDX_W = $clog2(MAX_LEN);

    logic [TS_W-1:0]                        ts_now;
    logic [NUM_STREAMS-1:0]                 en_cfg;
    logic [NUM_STREAMS-1:0][DEC_W-1:0]      dec_cfg;
    logic [NUM_STREAMS-1:0][1:0]            fmt_cfg;
    logic [LEN_W-1:0]                       len_cfg;
    logic [NUM_STREAMS-1:0]                 held, drain;
    logic [NUM_STREAMS-1:0][TS_W-1:0]       lane_ts;
    logic [NUM_STREAMS-1:0][LEN_W-1:0]      lane_len;
    logic [NUM_STREAMS-1:0][WORD_W-1:0]     lane_word;
    logic [IDX_W-1:0]                       rd_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_now <= '0;
        else        ts_now <= ts_now + TS_W'(1);
    end

    cfg_ctrl #(
        .NUM_STREAMS(NUM_STREAMS), .ID_W(ID_W), .DEC_W(DEC_W),
        .MAX_LEN(MAX_LEN), .DEF_LEN(DEF_LEN)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_stream(cmd_stream),
        .cmd_arg(cmd_arg), .cmd_ack(cmd_ack),
        .en_o(en_cfg), .dec_o(dec_cfg), .fmt_o(fmt_cfg), .len_o(len_cfg)
    );

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_lane
        stream_lane #(
            .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .DEC_W(DEC_W),
            .TS_W(TS_W), .MAX_LEN(MAX_LEN)
        ) u_lane (
            .clk(clk), .rst_n(rst_n),
            .en(en_cfg[i]), .dec(dec_cfg[i]), .fmt(fmt_cfg[i]), .len(len_cfg),
            .ts_now(ts_now),
            .s_valid(s_valid[i]), .s_data(s_data[i*SAMPLE_W +: SAMPLE_W]),
            .s_ready(s_ready[i]),
            .drain(drain[i]), .rd_idx(rd_idx),
            .held(held[i]), .ts_o(lane_ts[i]), .len_o(lane_len[i]),
            .rd_word(lane_word[i])
        );
    end

    pkt_tx #(
        .NUM_STREAMS(NUM_STREAMS), .ID_W(ID_W), .WORD_W(WORD_W),
        .TS_W(TS_W), .MAX_LEN(MAX_LEN)
    ) u_tx (
        .clk(clk), .rst_n(rst_n),
        .held(held), .ts_in(lane_ts), .len_in(lane_len), .word_in(lane_word),
        .drain(drain), .rd_idx(rd_idx),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
    );
endmodule

// File: rtl/meas_packer_chk.sv
`timescale 1ns/1ps
module meas_packer_chk #(
    parameter int NUM_STREAMS = 3,
    parameter int WORD_W      = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_STREAMS-1:0] s_ready,
    input logic [NUM_STREAMS-1:0] en_cfg,
    input logic                   cmd_valid,
    input logic                   cmd_ack,
    input logic                   m_tvalid,
    input logic                   m_tready,
    input logic [WORD_W-1:0]      m_tdata,
    input logic                   m_tlast
);
    // R9
    ack_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> cmd_ack);

    // R9
    ack_only_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_ack);

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_off
        // R5
        off_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_cfg[i] |-> !s_ready[i]);
    end
endmodule

bind meas_packer meas_packer_chk #(
    .NUM_STREAMS(NUM_STREAMS), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .en_cfg(en_cfg),
    .cmd_valid(cmd_valid), .cmd_ack(cmd_ack),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
);

// File: tb/meas_packer_bench.sv
`timescale 1ns/1ps
module meas_packer_bench;
    localparam int N  = 3;
    localparam int SW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    s_valid = '0;
    logic [N*SW-1:0] s_data = '0;
    logic [N-1:0]    s_ready;
    logic            cmd_valid = 1'b0;
    logic [1:0]      cmd_op = '0;
    logic [3:0]      cmd_stream = '0;
    logic [7:0]      cmd_arg = '0;
    logic            cmd_ack;
    logic            m_tvalid;
    logic            m_tready = 1'b0;
    logic [31:0]     m_tdata;
    logic            m_tlast;

    meas_packer u_meas_packer (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_stream(cmd_stream), .cmd_arg(cmd_arg),
        .cmd_ack(cmd_ack), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tdata(m_tdata), .m_tlast(m_tlast)
    );

    always #10 clk = ~clk;

    int bts;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) bts <= 0;
        else        bts <= bts + 1;
    end

    logic [31:0] cap_d [0:511];
    logic        cap_l [0:511];
    int          ncap = 0;
    int          rp = 0;
    always @(negedge clk) begin
        if (rst_n && m_tvalid && m_tready) begin
            cap_d[ncap] <= m_tdata;
            cap_l[ncap] <= m_tlast;
            ncap <= ncap + 1;
        end
    end

    int nchk = 0;
    int nbad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input int op, input int s, input int arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_stream = 4'(s); cmd_arg = 8'(arg);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 ack pulse", 32'(cmd_ack), 32'd1);
    endtask

    task automatic push(input int s, input logic [15:0] d, output int st);
        @(negedge clk);
        s_valid[s] = 1'b1;
        s_data[s*SW +: SW] = d;
        while (!s_ready[s]) @(negedge clk);
        st = bts;
        @(negedge clk);
        s_valid[s] = 1'b0;
    endtask

    task automatic beat(input string req, input logic [31:0] d, input logic l);
        while (ncap <= rp) @(negedge clk);
        chk(req, cap_d[rp], d);
        chk({req, " tlast"}, 32'(cap_l[rp]), 32'(l));
        rp++;
    endtask

    function automatic logic [31:0] hdr(input int id, input int st);
        return {4'(id), 28'(st)};
    endfunction

    // format code, sample, expected payload word
    localparam logic [49:0] FMT_VEC [5] = '{
        {2'd0, 16'h8001, 32'h0000_8001},
        {2'd1, 16'h8001, 32'hFFFF_8001},
        {2'd1, 16'h7FFF, 32'h0000_7FFF},
        {2'd2, 16'hABCD, 32'h0000_00AB},
        {2'd3, 16'h1234, 32'h0000_1234}
    };

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        int st, st0, st1, st2, dummy;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 tvalid", 32'(m_tvalid), 0);
        chk("R11 tlast", 32'(m_tlast), 0);
        chk("R11 ack", 32'(cmd_ack), 0);
        chk("R11 s_ready", 32'(s_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 off after reset", 32'(s_ready), 0);
        m_tready = 1'b1;

        cmd(0, 0, 1);
        cmd(3, 0, 1);
        @(negedge clk);
        chk("R9 ack falls", 32'(cmd_ack), 0);
        chk("R5 enabled ready", 32'(s_ready[0]), 1);

        // format table, R3 with R1/R2 header checks
        for (int i = 0; i < 5; i++) begin
            cmd(2, 0, int'(FMT_VEC[i][49:48]));
            push(0, FMT_VEC[i][47:32], st);
            beat("R1 R2 header", hdr(0, st), 1'b0);
            beat("R3 format", FMT_VEC[i][31:0], 1'b1);
        end

        // R3 format latched at packet start
        cmd(2, 0, 0);
        cmd(3, 0, 2);
        push(0, 16'h8000, st);
        cmd(2, 0, 1);
        push(0, 16'h8000, dummy);
        beat("R1 header", hdr(0, st), 1'b0);
        beat("R3 boundary w0", 32'h0000_8000, 1'b0);
        beat("R3 boundary w1", 32'h0000_8000, 1'b1);
        cmd(3, 0, 1);
        push(0, 16'h8000, st);
        beat("R2 header", hdr(0, st), 1'b0);
        beat("R3 new format", 32'hFFFF_8000, 1'b1);

        // R6 length latched and clamped, R7 tlast position
        cmd(3, 0, 3);
        push(0, 16'h0011, st);
        cmd(3, 0, 0);
        push(0, 16'h0022, dummy);
        push(0, 16'h0033, dummy);
        beat("R6 header", hdr(0, st), 1'b0);
        beat("R7 w0", 32'h11, 1'b0);
        beat("R7 w1", 32'h22, 1'b0);
        beat("R6 w2", 32'h33, 1'b1);
        push(0, 16'h0044, st);
        beat("R6 zero clamps header", hdr(0, st), 1'b0);
        beat("R6 zero clamps to one", 32'h44, 1'b1);
        cmd(3, 0, 200);
        for (int i = 0; i < 8; i++) begin
            push(0, 16'(16'h0100 + i), dummy);
            if (i == 0) st = dummy;
            if (i == 6) begin
                repeat (3) @(negedge clk);
                chk("R6 no partial send", 32'(ncap), 32'(rp));
            end
        end
        beat("R6 long header", hdr(0, st), 1'b0);
        for (int i = 0; i < 8; i++)
            beat("R6 R7 long word", 32'(16'h0100 + i), i == 7);

        // R4 thinning keep one in three
        cmd(0, 1, 1);
        cmd(1, 1, 2);
        cmd(3, 0, 2);
        push(1, 16'd10, st);
        for (int v = 11; v <= 15; v++) push(1, 16'(v), dummy);
        beat("R4 header", hdr(1, st), 1'b0);
        beat("R4 first kept", 32'd10, 1'b0);
        beat("R4 fourth kept", 32'd13, 1'b1);
        repeat (4) @(negedge clk);
        chk("R4 dropped consumed", 32'(ncap), 32'(rp));

        // R5 disabled stream takes nothing
        cmd(1, 1, 0);
        cmd(0, 1, 0);
        @(negedge clk);
        s_valid[1] = 1'b1;
        s_data[SW +: SW] = 16'h0099;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R5 ready low", 32'(s_ready[1]), 0);
        end
        s_valid[1] = 1'b0;
        chk("R5 nothing sent", 32'(ncap), 32'(rp));
        cmd(0, 1, 1);
        cmd(3, 0, 1);
        push(1, 16'h0055, st);
        beat("R5 header", hdr(1, st), 1'b0);
        beat("R5 only new sample", 32'h55, 1'b1);

        // R8 round robin with three packets ready together, R10 stall
        cmd(0, 2, 1);
        cmd(3, 0, 2);
        m_tready = 1'b0;
        fork
            begin push(0, 16'h0A01, st0); push(0, 16'h0A02, dummy); end
            begin push(1, 16'h0B01, st1); push(1, 16'h0B02, dummy); end
            begin push(2, 16'h0C01, st2); push(2, 16'h0C02, dummy); end
        join
        repeat (2) @(negedge clk);
        chk("R10 stalled valid", 32'(m_tvalid), 1);
        chk("R10 stalled data", m_tdata, hdr(2, st2));
        repeat (3) @(negedge clk);
        chk("R10 held data", m_tdata, hdr(2, st2));
        chk("R7 no tlast on header", 32'(m_tlast), 0);
        m_tready = 1'b1;
        beat("R8 first is stream 2", hdr(2, st2), 1'b0);
        beat("R8 s2 w0", 32'h0C01, 1'b0);
        beat("R8 s2 w1", 32'h0C02, 1'b1);
        beat("R8 then stream 0", hdr(0, st0), 1'b0);
        beat("R8 s0 w0", 32'h0A01, 1'b0);
        beat("R8 s0 w1", 32'h0A02, 1'b1);
        beat("R8 then stream 1", hdr(1, st1), 1'b0);
        beat("R8 s1 w0", 32'h0B01, 1'b0);
        beat("R8 s1 w1", 32'h0B02, 1'b1);
        chk("R2 shared timestamp", 32'(st0), 32'(st2));

        repeat (5) @(negedge clk);
        chk("R8 output idle", 32'(m_tvalid), 0);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule